// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Request Latching and Masking

This block sits between eight peripheral request lines and a processor core. Each request is captured in its own bit of a pending register and stays there until software clears it. A program-written mask register is ANDed with the pending bits. A fixed priority encoder then picks the winner, and the lowest bit index wins. A registered status flag reports whether any unmasked request is pending.

The core pulses `instr_end` when an instruction finishes. At that point the controller starts an interrupt cycle only if both the status flag and a global enable flag are set. On entry it raises `intr_cycle` for one clock and clears the global enable. It also latches a vector address that points at the winning source's service slot.

All software control goes through one narrow write port. A select field chooses between three operations: load the mask, set or clear the global enable, and clear chosen pending bits.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no request is pending, the mask is all zeros (every source blocked), the global enable is 0, `ist` and `intr_cycle` are 0, and `vec_addr` equals the base address `VEC_BASE`.
- R2: A request line that is high at a clock edge sets its pending bit. The bit stays set after the line returns low.
- R3: A write with `wr_sel`=0 loads `wr_data` into the mask. A pending source whose mask bit is 0 does not raise `ist`. Once its mask bit is set to 1, it raises `ist` without being requested again.
- R4: When several unmasked sources are pending, the one with the lowest bit index wins, and bit 0 has the highest priority.
- R5: The latched vector equals `VEC_BASE` with the winner's 3-bit index placed in bits [4:2], so each source gets a 4-word slot.
- R6: `intr_cycle` pulses for exactly one cycle, on the edge after an edge where `instr_end`, the enable and `ist` are all 1. In every other case it stays 0.
- R7: Entering an interrupt cycle clears the global enable. A later `instr_end` starts no cycle until software sets the enable again.
- R8: A write with `wr_sel`=2 clears each pending bit whose `wr_data` bit is 1. If that source's request is high on the same edge, the request wins and the bit stays set.
- R9: `ist` returns to 0 one edge after no unmasked request remains pending.
- R10: The global enable changes only through a write with `wr_sel`=1, which loads `wr_data[0]`, or through the automatic clear on entry. `wr_sel`=3 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Peripheral request lines, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 mask, 1 enable, 2 clear pending, 3 no-op |
| wr_data | input | NUM_SRC | Write data |
| instr_end | input | 1 | End-of-instruction strobe from the core |
| ist | output | 1 | Registered status: an unmasked request is pending |
| vec_addr | output | ADDR_W | Vector latched on interrupt-cycle entry |
| intr_cycle | output | 1 | One-cycle interrupt-cycle start pulse |

## Verification
The bench builds the block with its defaults: eight sources, a 16-bit vector and base 0x0100. With these values every one of the eight slot offsets, from 0x00 to 0x1C, can be told apart in the vector's low byte. It therefore covers the extreme priorities, bit 0 against bit 7, as well as mid-range pairs. The eight-bit mask and clear fields also allow the bench to block a higher source while a lower one wins, and to collide a clear with a new request on a single bit.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [1:0] {
        WSEL_MASK = 2'd0,
        WSEL_IEN  = 2'd1,
        WSEL_CLR  = 2'd2,
        WSEL_NOP  = 2'd3
    } wsel_e;

    typedef struct packed {
        logic mask_wr;
        logic ien_wr;
        logic clr_wr;
    } wcmd_t;

    function automatic wcmd_t decode_wr(input logic en, input logic [1:0] sel);
        wcmd_t c;
        c.mask_wr = en && (wsel_e'(sel) == WSEL_MASK);
        c.ien_wr  = en && (wsel_e'(sel) == WSEL_IEN);
        c.clr_wr  = en && (wsel_e'(sel) == WSEL_CLR);
        return c;
    endfunction

endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    // Each source holds its own bit; a new request outranks a clear.
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend[g] <= 1'b0;
            else if (req[g])
                pend[g] <= 1'b1;
            else if (clr[g])
                pend[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  mask,
    output logic          valid,
    output logic [IW-1:0] idx
);
    logic [N-1:0] live;
    assign live = pend & mask;

    // Scan from the top down so the lowest set index is the last one written.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_cycle_ctl.sv
module irq_cycle_ctl #(
    parameter int              IW       = 3,
    parameter int              AW       = 16,
    parameter int              SHIFT    = 2,
    parameter logic [AW-1:0]   BASE     = 'h100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enc_valid,
    input  logic [IW-1:0] enc_idx,
    input  logic          instr_end,
    input  logic          ien_wr,
    input  logic          ien_val,
    output logic          ist,
    output logic          ien,
    output logic          intr_cycle,
    output logic [AW-1:0] vec_addr
);
    logic [IW-1:0] ist_idx;
    logic          take;

    assign take = instr_end && ien && ist;

    // Status stage: flag and winning index registered together.
    always_ff @(posedge clk) begin
        if (rst) begin
            ist     <= 1'b0;
            ist_idx <= '0;
        end else begin
            ist     <= enc_valid;
            ist_idx <= enc_idx;
        end
    end

    // Enable flag: entry clear takes precedence over a software write.
    always_ff @(posedge clk) begin
        if (rst)
            ien <= 1'b0;
        else if (take)
            ien <= 1'b0;
        else if (ien_wr)
            ien <= ien_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            intr_cycle <= 1'b0;
            vec_addr   <= BASE;
        end else begin
            intr_cycle <= take;
            if (take)
                vec_addr <= BASE | (AW'(ist_idx) << SHIFT);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int                 NUM_SRC    = 8,
    parameter int                 ADDR_W     = 16,
    parameter int                 SLOT_SHIFT = 2,
    parameter logic [ADDR_W-1:0]  VEC_BASE   = 'h100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic               instr_end,
    output logic               ist,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic               intr_cycle
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    wcmd_t              cmd;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clr_vec;
    logic               enc_valid;
    logic [IDX_W-1:0]   enc_idx;
    logic               ien_q;

    assign cmd     = decode_wr(wr_en, wr_sel);
    assign clr_vec = cmd.clr_wr ? wr_data : '0;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (cmd.mask_wr)
            mask_q <= wr_data;
    end

    irq_latch_bank #(.N(NUM_SRC)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .req  (irq_req),
        .clr  (clr_vec),
        .pend (pend_q)
    );

    irq_prio_enc #(.N(NUM_SRC), .IW(IDX_W)) u_enc (
        .pend  (pend_q),
        .mask  (mask_q),
        .valid (enc_valid),
        .idx   (enc_idx)
    );

    irq_cycle_ctl #(
        .IW    (IDX_W),
        .AW    (ADDR_W),
        .SHIFT (SLOT_SHIFT),
        .BASE  (VEC_BASE)
    ) u_cyc (
        .clk        (clk),
        .rst        (rst),
        .enc_valid  (enc_valid),
        .enc_idx    (enc_idx),
        .instr_end  (instr_end),
        .ien_wr     (cmd.ien_wr),
        .ien_val    (wr_data[0]),
        .ist        (ist),
        .ien        (ien_q),
        .intr_cycle (intr_cycle),
        .vec_addr   (vec_addr)
    );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] irq_req,
    input logic [N-1:0] pend,
    input logic [N-1:0] mask,
    input logic [N-1:0] clr,
    input logic         ien,
    input logic         ist,
    input logic         instr_end,
    input logic         intr_cycle
);
    // R2: a request seen at an edge is pending afterwards
    assert_req_captured_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(irq_req) & ~pend) == '0));

    // R8: pending bits only drop where a clear was written
    assert_pend_held_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0));

    // R9: nothing unmasked pending means status low next edge
    assert_ist_drop_R9: assert property (@(posedge clk) disable iff (rst)
        ((pend & mask) == '0) |=> !ist);

    // R6: a cycle starts only from the three conditions together
    assert_cycle_cause_R6: assert property (@(posedge clk) disable iff (rst)
        !(instr_end && ien && ist) |=> !intr_cycle);

    // R7: entry leaves the enable cleared
    assert_ien_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        intr_cycle |-> !ien);

    // R6: the pulse never lasts two cycles
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        intr_cycle |=> !intr_cycle);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.N(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .pend       (pend_q),
    .mask       (mask_q),
    .clr        (clr_vec),
    .ien        (ien_q),
    .ist        (ist),
    .instr_end  (instr_end),
    .intr_cycle (intr_cycle)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    localparam int N  = 8;
    localparam int AW = 16;
    localparam logic [AW-1:0] BASE = 16'h0100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_req = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd3;
    logic [N-1:0]  wr_data = '0;
    logic          instr_end = 1'b0;
    logic          ist;
    logic [AW-1:0] vec_addr;
    logic          intr_cycle;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW), .SLOT_SHIFT(2), .VEC_BASE(BASE)) u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .instr_end(instr_end), .ist(ist), .vec_addr(vec_addr),
        .intr_cycle(intr_cycle)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [N-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic pulse_req(input logic [N-1:0] bits);
        @(negedge clk);
        irq_req = bits;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    // Pulses instr_end; checks whether a cycle started and, if so, the vector.
    task automatic enter(input string tag, input bit exp_cyc, input logic [AW-1:0] exp_vec);
        @(negedge clk);
        instr_end = 1'b1;
        @(negedge clk);
        instr_end = 1'b0;
        chk({tag, " cycle"}, 32'(intr_cycle), 32'(exp_cyc));
        if (exp_cyc) chk({tag, " vector"}, 32'(vec_addr), 32'(exp_vec));
        @(negedge clk);
        chk({tag, " pulse end"}, 32'(intr_cycle), 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ist", 32'(ist), 32'd0);
        chk("R1 cycle", 32'(intr_cycle), 32'd0);
        chk("R1 vector", 32'(vec_addr), 32'(BASE));
        enter("R1 idle entry", 1'b0, '0);
    endtask

    task automatic t_mask_and_hold();
        pulse_req(8'h20);
        settle();
        chk("R3 masked source", 32'(ist), 32'd0);
        wr(2'd0, 8'hFF);
        settle();
        chk("R2 held after line low / R3 unmask", 32'(ist), 32'd1);
        enter("R6 enable off", 1'b0, '0);
        wr(2'd1, 8'h01);
        enter("R5 source 5", 1'b1, 16'h0114);
        enter("R7 enable auto-cleared", 1'b0, '0);
        wr(2'd2, 8'h20);
        settle();
        chk("R9 ist after clear", 32'(ist), 32'd0);
    endtask

    task automatic t_priority();
        pulse_req(8'h90);
        settle();
        wr(2'd1, 8'h01);
        enter("R4 bit4 over bit7", 1'b1, 16'h0110);
        wr(2'd2, 8'h10);
        settle();
        chk("R8 bit7 still pending", 32'(ist), 32'd1);
        wr(2'd1, 8'h01);
        enter("R5 source 7", 1'b1, 16'h011C);
        pulse_req(8'h01);
        settle();
        wr(2'd1, 8'h01);
        enter("R4 bit0 highest", 1'b1, 16'h0100);
        wr(2'd2, 8'hFF);
        settle();
        chk("R9 all cleared", 32'(ist), 32'd0);
    endtask

    task automatic t_mask_high();
        pulse_req(8'h42);
        wr(2'd0, 8'hFD);
        settle();
        wr(2'd1, 8'h01);
        enter("R3 masked bit1 loses to bit6", 1'b1, 16'h0118);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h01);
        settle();
        enter("R4 bit1 once unmasked", 1'b1, 16'h0104);
        wr(2'd2, 8'h42);
        settle();
    endtask

    task automatic t_collision();
        pulse_req(8'h08);
        settle();
        @(negedge clk);
        irq_req = 8'h08; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h08;
        @(negedge clk);
        irq_req = '0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
        settle();
        chk("R8 request beats clear", 32'(ist), 32'd1);
        wr(2'd1, 8'h01);
        enter("R8 bit3 vector", 1'b1, 16'h010C);
    endtask

    task automatic t_enable_ctl();
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h00);
        enter("R10 enable written off", 1'b0, '0);
        wr(2'd3, 8'hFF);
        enter("R10 no-op select", 1'b0, '0);
        chk("R10 pending kept by no-op", 32'(ist), 32'd1);
        wr(2'd1, 8'h01);
        repeat (4) @(negedge clk);
        chk("R6 no instr_end no cycle", 32'(intr_cycle), 32'd0);
        enter("R6 entry after wait", 1'b1, 16'h010C);
        wr(2'd2, 8'h08);
        settle();
        chk("R9 final clear", 32'(ist), 32'd0);
    endtask

    initial begin
        t_reset();
        t_mask_and_hold();
        t_priority();
        t_mask_high();
        t_collision();
        t_enable_ctl();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule